// File: doc/BRIEF.md
# Debug Stream Packet Deframer

The deframer takes a raw byte stream with a valid/ready handshake, typically from a serial or USB receive FIFO. It cuts that stream into tagged debug packets. It searches for a four-byte opening marker by sliding a window over the incoming bytes. Each byte that leaves the window before a match counts as lost. After the marker comes a four-byte header: one identifier byte, then a payload length of three bytes with the most significant byte first.

Payload bytes go straight through to a downstream valid/ready byte port that marks the first and the last byte of the packet. Filler bytes that round the payload up to a 4-byte boundary are swallowed. The four bytes after that are compared against a closing marker. The identifier and the length stay on sideband outputs while the packet is open. Single-cycle pulses report a closed packet, a bad closing marker, an unknown identifier and the number of bytes lost before the last opening marker.

Top module: `dbg_deframer`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, `out_valid` is 0, `pkt_active` is 0, `drop_count` is 0, and none of the pulse outputs is asserted.
- R2: A packet opens when the last four accepted bytes are 0x44, 0x4D, 0x41, 0x40 in arrival order ("DMA@"). The window is filled afresh after every packet and after reset.
- R3: While searching, each byte pushed out of the full four-byte window counts as dropped. This includes a byte pushed out by the marker's final byte. When the marker completes and the count is non-zero, `drop_count` takes the count for good and `drop_pulse` is high for one cycle. The internal count then restarts at zero. The count is `DROP_W` bits wide and saturates at all ones.
- R4: The header byte after the marker is the identifier. The next three bytes are the length, most significant byte first. From the cycle after the last header byte until the cycle after the last trailer byte, `pkt_active` is 1 and `pkt_id`/`pkt_len` hold the header values.
- R5: Exactly `pkt_len` payload bytes are forwarded in arrival order on `out_data`. `out_first` marks the first byte and `out_last` marks byte `pkt_len-1`. `out_valid` is never high outside a payload.
- R6: After the payload, filler bytes are consumed up to the next multiple of 4 of the payload size. They never appear on the output.
- R7: With a length of zero, no payload or filler is read. The four bytes after the header are the trailer.
- R8: A trailer of 0x43, 0x4D, 0x50, 0x48 ("CMPH") gives a one-cycle `pkt_done` pulse. Any other four bytes give a one-cycle `tail_err` pulse. In both cases searching resumes with an empty window.
- R9: Identifiers 0x01, 0xF1, 0xF2 and 0xF3 are known. Any other identifier gives a one-cycle `unknown_id` pulse in the cycle after the last header byte, and its payload is still consumed and forwarded.
- R10: During the payload, `in_ready` equals `out_ready`. Outside the payload, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| out_valid | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_first | output | 1 | First payload byte of the packet |
| out_last | output | 1 | Last payload byte of the packet |
| out_ready | input | 1 | Downstream accepts the payload byte |
| pkt_id | output | 8 | Identifier of the open packet |
| pkt_len | output | 24 | Payload length of the open packet |
| pkt_active | output | 1 | Header decoded, trailer not yet checked |
| unknown_id | output | 1 | Pulse: identifier not in the known set |
| pkt_done | output | 1 | Pulse: trailer matched |
| tail_err | output | 1 | Pulse: trailer mismatched |
| drop_pulse | output | 1 | Pulse: drop_count was just updated |
| drop_count | output | DROP_W | Bytes dropped before the last opening marker |

## Verification
The bench builds the block with `DROP_W` set to 4, so the dropped-byte counter saturates at 15. A run of twenty junk bytes ahead of a marker therefore exercises saturation, and the next packet's small count shows that the counter restarted. The table covers several payload lengths across all four residues modulo 4, including zero. It also covers an unknown identifier, a corrupted trailer and a stalling downstream. Directed steps add a reset in the middle of a packet and a stall held on a payload byte.

// File: rtl/dbg_deframer.sv
module dbg_deframer #(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_first,
  output logic              out_last,
  input  logic              out_ready,
  output logic [7:0]        pkt_id,
  output logic [23:0]       pkt_len,
  output logic              pkt_active,
  output logic              unknown_id,
  output logic              pkt_done,
  output logic              tail_err,
  output logic              drop_pulse,
  output logic [DROP_W-1:0] drop_count
);
  localparam int          LEN_W = 24;
  localparam logic [31:0] OPEN  = 32'h444D_4140;
  localparam logic [31:0] CLOSE = 32'h434D_5048;

  typedef enum logic [2:0] {S_HUNT, S_HDR, S_PAY, S_PAD, S_TAIL} st_t;

  st_t               st;
  logic [31:0]       win;
  logic [2:0]        fill;
  logic [1:0]        idx;
  logic [LEN_W-1:0]  cnt;
  logic [DROP_W-1:0] dcnt;

  wire               acc       = in_valid & in_ready;
  wire [31:0]        nwin      = {win[23:0], in_data};
  wire               shift_out = (fill == 3'd4);
  wire [DROP_W-1:0]  dnext     = (shift_out && !(&dcnt)) ? dcnt + 1'b1 : dcnt;
  wire               hit       = (fill >= 3'd3) && (nwin == OPEN);
  wire [LEN_W-1:0]   cnt_inc   = cnt + 1'b1;
  wire [LEN_W-1:0]   hdr_len   = {pkt_len[15:0], in_data};
  wire               known     = (pkt_id == 8'h01) || (pkt_id == 8'hF1) ||
                                 (pkt_id == 8'hF2) || (pkt_id == 8'hF3);

  assign in_ready  = (st == S_PAY) ? out_ready : 1'b1;
  assign out_valid = (st == S_PAY) && in_valid;
  assign out_data  = in_data;
  assign out_first = (cnt == '0);
  assign out_last  = (cnt_inc == pkt_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_HUNT;
      win        <= '0;
      fill       <= '0;
      idx        <= '0;
      cnt        <= '0;
      dcnt       <= '0;
      pkt_id     <= '0;
      pkt_len    <= '0;
      pkt_active <= 1'b0;
      unknown_id <= 1'b0;
      pkt_done   <= 1'b0;
      tail_err   <= 1'b0;
      drop_pulse <= 1'b0;
      drop_count <= '0;
    end else begin
      unknown_id <= 1'b0;
      pkt_done   <= 1'b0;
      tail_err   <= 1'b0;
      drop_pulse <= 1'b0;
      if (acc) begin
        case (st)
          S_HUNT: begin
            win <= nwin;
            if (hit) begin
              st   <= S_HDR;
              idx  <= '0;
              fill <= '0;
              dcnt <= '0;
              if (dnext != '0) begin
                drop_count <= dnext;
                drop_pulse <= 1'b1;
              end
            end else begin
              if (!shift_out) fill <= fill + 3'd1;
              dcnt <= dnext;
            end
          end
          S_HDR: begin
            idx <= idx + 2'd1;
            if (idx == 2'd0) pkt_id <= in_data;
            else pkt_len <= hdr_len;
            if (idx == 2'd3) begin
              pkt_active <= 1'b1;
              unknown_id <= !known;
              cnt        <= '0;
              st         <= (hdr_len == '0) ? S_TAIL : S_PAY;
            end
          end
          S_PAY: begin
            cnt <= cnt_inc;
            if (cnt_inc == pkt_len)
              st <= (pkt_len[1:0] == 2'd0) ? S_TAIL : S_PAD;
          end
          S_PAD: begin
            cnt <= cnt_inc;
            if (cnt_inc[1:0] == 2'd0) st <= S_TAIL;
          end
          S_TAIL: begin
            win <= nwin;
            idx <= idx + 2'd1;
            if (idx == 2'd3) begin
              st         <= S_HUNT;
              pkt_active <= 1'b0;
              if (nwin == CLOSE) pkt_done <= 1'b1;
              else tail_err <= 1'b1;
            end
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_deframer_chk.sv
module dbg_deframer_chk #(
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        pkt_id,
  input logic [23:0]       pkt_len,
  input logic              pkt_active,
  input logic              unknown_id,
  input logic              pkt_done,
  input logic              tail_err,
  input logic              drop_pulse,
  input logic [DROP_W-1:0] drop_count
);
  assert_out_in_pkt_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> pkt_active);

  assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !pkt_active |-> in_ready);

  assert_end_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(pkt_done && tail_err));

  assert_end_closes_R4: assert property (@(posedge clk) disable iff (rst)
    (pkt_done || tail_err) |-> !pkt_active);

  assert_side_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (pkt_active && $past(pkt_active)) |-> ($stable(pkt_id) && $stable(pkt_len)));

  assert_drop_nz_R3: assert property (@(posedge clk) disable iff (rst)
    drop_pulse |-> (drop_count != '0));

  assert_unk_open_R9: assert property (@(posedge clk) disable iff (rst)
    unknown_id |-> (pkt_active && !$past(pkt_active)));

  assert_unk_set_R9: assert property (@(posedge clk) disable iff (rst)
    unknown_id |-> (pkt_id != 8'h01 && pkt_id != 8'hF1 && pkt_id != 8'hF2 && pkt_id != 8'hF3));
endmodule

bind dbg_deframer dbg_deframer_chk #(.DROP_W(DROP_W)) u_chk (.*);

// File: tb/test_dbg_deframer.sv
module test_dbg_deframer;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready;
  logic          out_valid;
  logic [7:0]    out_data;
  logic          out_first;
  logic          out_last;
  logic          out_ready = 1'b1;
  logic [7:0]    pkt_id;
  logic [23:0]   pkt_len;
  logic          pkt_active;
  logic          unknown_id;
  logic          pkt_done;
  logic          tail_err;
  logic          drop_pulse;
  logic [DW-1:0] drop_count;

  always #10 clk = ~clk;

  dbg_deframer #(.DROP_W(DW)) i_dbg_deframer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first), .out_last(out_last),
    .out_ready(out_ready), .pkt_id(pkt_id), .pkt_len(pkt_len), .pkt_active(pkt_active),
    .unknown_id(unknown_id), .pkt_done(pkt_done), .tail_err(tail_err),
    .drop_pulse(drop_pulse), .drop_count(drop_count)
  );

  // junk[39:32] id[31:24] len[23:8] good[1] stall[0]
  localparam logic [39:0] VEC [7] = '{
    {8'd0,  8'h01, 16'd5, 8'b10},
    {8'd3,  8'hF1, 16'd4, 8'b11},
    {8'd0,  8'hF2, 16'd0, 8'b10},
    {8'd2,  8'h7E, 16'd6, 8'b10},
    {8'd0,  8'hF3, 16'd3, 8'b00},
    {8'd20, 8'h01, 16'd1, 8'b11},
    {8'd1,  8'h01, 16'd8, 8'b10}
  };

  int nvec = 0, nbad = 0;
  bit stall = 1'b0;
  int tog = 0;

  logic [7:0] mb [64];
  bit mf [64];
  bit ml [64];
  int mn, mdone, merr, munk, mdrops, mdropval, mid, mlen;
  bit pact = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    mn = 0; mdone = 0; merr = 0; munk = 0; mdrops = 0; mdropval = -1; mid = -1; mlen = -1;
  endtask

  always @(negedge clk) begin
    #5;
    if (!rst) begin
      if (out_valid && out_ready) begin
        if (mn < 64) begin
          mb[mn] = out_data; mf[mn] = out_first; ml[mn] = out_last;
        end
        mn++;
      end
      if (pkt_done) mdone++;
      if (tail_err) merr++;
      if (unknown_id) munk++;
      if (drop_pulse) begin mdrops++; mdropval = int'(drop_count); end
      if (pkt_active && !pact) begin mid = int'(pkt_id); mlen = int'(pkt_len); end
      pact = pkt_active;
    end else pact = 1'b0;
  end

  task automatic sb(input logic [7:0] b);
    bit r;
    in_valid = 1'b1;
    in_data  = b;
    do begin
      if (stall) begin tog++; out_ready = (tog % 3 != 0); end
      else out_ready = 1'b1;
      #1 r = in_ready;
      @(negedge clk);
    end while (!r);
    in_valid = 1'b0;
    out_ready = 1'b1;
  endtask

  function automatic logic [7:0] pb(input int v, input int j);
    return 8'((v * 16 + j * 7 + 3) & 255);
  endfunction

  task automatic send_head(input int junk, input logic [7:0] id, input int len);
    for (int i = 0; i < junk; i++) sb(8'(8'h11 + i));
    sb(8'h44); sb(8'h4D); sb(8'h41); sb(8'h40);
    sb(id); sb(8'((len >> 16) & 255)); sb(8'((len >> 8) & 255)); sb(8'(len & 255));
  endtask

  task automatic send_rest(input int v, input int len, input bit good);
    for (int j = 0; j < len; j++) sb(pb(v, j));
    for (int p = len; p % 4 != 0; p++) sb(8'hEE);
    sb(8'h43); sb(8'h4D); sb(8'h50); sb(good ? 8'h48 : 8'h58);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    clr_mon();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 pkt_active", int'(pkt_active), 0);
    chk("R1 drop_count", int'(drop_count), 0);
    chk("R1 pulses", int'({drop_pulse, pkt_done, tail_err, unknown_id}), 0);
    @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      int junk, len, exp_drop, bad_data, bad_flag;
      logic [7:0] id;
      bit good, unk;
      junk  = int'(VEC[v][39:32]);
      id    = VEC[v][31:24];
      len   = int'(VEC[v][23:8]);
      good  = VEC[v][1];
      stall = VEC[v][0];
      unk   = !(id == 8'h01 || id == 8'hF1 || id == 8'hF2 || id == 8'hF3);
      clr_mon();
      send_head(junk, id, len);
      send_rest(v, len, good);
      stall = 1'b0;
      settle();
      bad_data = 0; bad_flag = 0;
      for (int j = 0; j < len && j < 64; j++) begin
        if (mb[j] != pb(v, j)) bad_data++;
        if (mf[j] != (j == 0) || ml[j] != (j == len - 1)) bad_flag++;
      end
      chk("R2/R4 id captured", mid, int'(id));
      chk("R4 length captured", mlen, len);
      chk("R5/R6/R7 payload count", mn, len);
      chk("R5 payload data", bad_data, 0);
      chk("R5 first/last flags", bad_flag, 0);
      chk("R8 done pulses", mdone, good ? 1 : 0);
      chk("R8 tail error pulses", merr, good ? 0 : 1);
      chk("R9 unknown id pulses", munk, unk ? 1 : 0);
      exp_drop = (junk > 15) ? 15 : junk;
      chk("R3 drop reports", mdrops, junk > 0 ? 1 : 0);
      if (junk > 0) chk("R3 drop value", mdropval, exp_drop);
    end

    // R10 held stall during payload
    clr_mon();
    send_head(0, 8'h01, 2);
    in_valid = 1'b1; in_data = 8'h5A; out_ready = 1'b0;
    #1;
    chk("R10 in_ready follows stalled out_ready", int'(in_ready), 0);
    chk("R5 out_valid in payload", int'(out_valid), 1);
    @(negedge clk); @(negedge clk);
    #1;
    chk("R10 still stalled", int'(in_ready), 0);
    chk("R10 no byte taken while stalled", mn, 0);
    in_valid = 1'b0; out_ready = 1'b1;
    send_rest(9, 2, 1'b1);
    settle();
    chk("R10 payload count after stall", mn, 2);
    chk("R10 packet closes", mdone, 1);

    // R1 reset mid-packet, then a clean packet
    clr_mon();
    send_head(0, 8'hF1, 4);
    sb(8'h01);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 pkt_active after reset", int'(pkt_active), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);
    @(negedge clk);
    clr_mon();
    send_head(0, 8'hF2, 1);
    send_rest(3, 1, 1'b1);
    settle();
    chk("R6 one byte then filler", mn, 1);
    chk("R8 done after reset", mdone, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule